// File: doc/BRIEF.md
# Programming-Mode Entry and Exit Sequencer

This block is the host side of a serial in-circuit programming link. It drives three lines toward a target device: an enable for the high programming voltage on the target's reset pin, a serial clock and a serial data line. On a start request it puts the target into its serial program/verify mode. It pulses the voltage enable briefly and drops it. It waits a minimum quiet time and clocks out a fixed 32-bit entry key, most significant bit first. It then raises the voltage enable again and holds it. Once a settle interval has passed, it reports that the link is ready for programming traffic.

On a stop request from the ready state, it keeps the voltage applied for a minimum quiet interval after the last line activity, then removes it and returns to idle. Every interval is a cycle-count parameter of the host clock. The serial clock period is set by a divide parameter. Commands, erase, verify and the analog drive itself belong to other blocks.

Top module: `pgm_entry_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `vpp_en_o`, `sclk_o`, `sdat_o`, `busy_o` and `ready_o` are all low.
- R2: A `start_i` seen high at a clock edge while idle raises `vpp_en_o` from the next cycle for exactly `PULSE_CYC` cycles.
- R3: After the pulse, `vpp_en_o` is low for exactly `PRE_KEY_CYC` cycles before the first key bit appears. `sclk_o` stays low during that time.
- R4: The key `KEY` (default 32'h4D434850) is sent MSB first, one bit per serial clock period. Each period is `CLK_DIV` cycles low followed by `CLK_DIV` cycles high. `sdat_o` changes only at the start of a low phase, so it is stable across every rising edge.
- R5: The cycle after the last high phase, `vpp_en_o` rises with `sclk_o` and `sdat_o` low. `ready_o` rises after exactly the larger of `SETTLE_A_CYC` and `SETTLE_B_CYC` cycles.
- R6: While ready, `vpp_en_o` stays high and `sclk_o` and `sdat_o` stay low.
- R7: A `stop_i` seen high while ready keeps `vpp_en_o` high for exactly `EXIT_QUIET_CYC` further cycles, with both serial lines low. After that, all outputs go low (idle).
- R8: `busy_o` is high in every state except idle and ready. `ready_o` is high only in the ready state, so the two are never high together.
- R9: `start_i` is ignored in every state but idle, including ready. `stop_i` is ignored in every state but ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to enter program/verify mode |
| stop_i | input | 1 | Request to leave program/verify mode |
| vpp_en_o | output | 1 | Enable of the programming voltage on the target reset pin |
| sclk_o | output | 1 | Serial clock to the target |
| sdat_o | output | 1 | Serial data to the target |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Target in program/verify mode, data may be presented |

## Verification
The bench traces every cycle of an entry against a timeline built from the parameters. An off-by-one in any wait would shift the trace by one cycle and shows up as a mismatch in the phase that follows. The settle interval is set with the second value larger, so a design that waits for the first would raise `ready_o` early. The key trace catches a bit order reversed to LSB first and data that changes on the rising edge of the serial clock. Start and stop are injected in the middle of the key shift and again while ready; a design that restarts or exits on them breaks the trace or drops `ready_o`. The exit is timed from the stop request, so releasing the voltage early or late is also caught.

// File: rtl/pgm_seq_pkg.sv
// Package: shared state type and helpers for the programming-mode sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pgm_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PULSE    = 3'd1,
        ST_PRE_KEY  = 3'd2,
        ST_SHIFT    = 3'd3,
        ST_REAPPLY  = 3'd4,
        ST_READY    = 3'd5,
        ST_EXIT     = 3'd6
    } seq_state_e;

    // Larger of two interval counts.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_interval_timer.sv
// Module: down-counting interval timer.
// What it does: on load it takes a value N-1. It counts down to zero and holds
// there, and it flags expiry while the count is zero.
// Assumes: the caller loads it on the edge that enters a timed state, with N >= 1,
// so the state lasts exactly N cycles.
module seq_interval_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_q;

    // Load a fresh interval or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/key_serializer.sv
// Module: key serializer with serial clock generation.
// What it does: while enabled, it sends NBITS key bits MSB first. Each bit takes
// CLK_DIV cycles with the clock low, then CLK_DIV cycles with it high. Data
// moves only when the clock falls. done_o marks the final cycle.
// Assumes: en_i rises on the cycle the shift starts and drops the cycle after
// done_o. While disabled, all counters are cleared and both lines are low.
module key_serializer #(
    parameter int          NBITS   = 32,
    parameter logic [NBITS-1:0] KEY = 32'h4D434850,
    parameter int          CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sclk_o,
    output logic sdat_o,
    output logic done_o
);

    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
    localparam logic [IW-1:0] BIT_LAST = IW'(NBITS - 1);

    logic [DW-1:0] div_q;
    logic          high_q;
    logic [IW-1:0] idx_q;
    logic          half_end;

    assign half_end = (div_q == DIV_LAST);

    // Step the half-period divider, the clock phase and the bit index.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            div_q  <= '0;
            high_q <= 1'b0;
            idx_q  <= '0;
        end else if (half_end) begin
            div_q  <= '0;
            high_q <= !high_q;
            if (high_q) begin
                idx_q <= idx_q + 1'b1;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign sclk_o = en_i && high_q;
    assign sdat_o = en_i && KEY[BIT_LAST - idx_q];
    assign done_o = en_i && high_q && half_end && (idx_q == BIT_LAST);

endmodule

// File: rtl/pgm_entry_seq.sv
// Module: programming-mode entry and exit sequencer (top).
// What it does: on start_i it runs pulse, pre-key wait, key shift, voltage
// reapply and settle wait, then holds the voltage and reports ready. On stop_i
// it waits a quiet interval and then releases the voltage.
// Assumes: every interval parameter is >= 1 and CLK_DIV >= 1. The requests are
// synchronous to clk. The outputs are registered or come from registers only.
module pgm_entry_seq
    import pgm_seq_pkg::*;
#(
    parameter int          PULSE_CYC      = 4,
    parameter int          PRE_KEY_CYC    = 6,
    parameter int          SETTLE_A_CYC   = 5,
    parameter int          SETTLE_B_CYC   = 9,
    parameter int          EXIT_QUIET_CYC = 7,
    parameter int          CLK_DIV        = 2,
    parameter int          KEY_BITS       = 32,
    parameter logic [KEY_BITS-1:0] KEY    = 32'h4D434850
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic vpp_en_o,
    output logic sclk_o,
    output logic sdat_o,
    output logic busy_o,
    output logic ready_o
);

    localparam int SETTLE_CYC = max2(SETTLE_A_CYC, SETTLE_B_CYC);
    localparam int LONGEST    = max2(max2(PULSE_CYC, PRE_KEY_CYC),
                                     max2(SETTLE_CYC, EXIT_QUIET_CYC));
    localparam int CW         = $clog2(LONGEST + 1);

    seq_state_e state_q, state_d;
    logic       tmr_load, tmr_expired, key_done;
    logic [CW-1:0] tmr_val;
    logic       vpp_q, busy_q, ready_q;

    // Reload value (length minus one) for the timed state being entered.
    function automatic logic [CW-1:0] reload_for(input seq_state_e s);
        case (s)
            ST_PULSE:   return CW'(PULSE_CYC - 1);
            ST_PRE_KEY: return CW'(PRE_KEY_CYC - 1);
            ST_REAPPLY: return CW'(SETTLE_CYC - 1);
            ST_EXIT:    return CW'(EXIT_QUIET_CYC - 1);
            default:    return '0;
        endcase
    endfunction

    // Next-state decision: each step waits on its timer, the key or a request.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (start_i)     state_d = ST_PULSE;
            ST_PULSE:   if (tmr_expired) state_d = ST_PRE_KEY;
            ST_PRE_KEY: if (tmr_expired) state_d = ST_SHIFT;
            ST_SHIFT:   if (key_done)    state_d = ST_REAPPLY;
            ST_REAPPLY: if (tmr_expired) state_d = ST_READY;
            ST_READY:   if (stop_i)      state_d = ST_EXIT;
            ST_EXIT:    if (tmr_expired) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_d != state_q);
    assign tmr_val  = reload_for(state_d);

    // State register and registered line/status decode of the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vpp_q   <= 1'b0;
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            vpp_q   <= (state_d == ST_PULSE) || (state_d == ST_REAPPLY) ||
                       (state_d == ST_READY) || (state_d == ST_EXIT);
            busy_q  <= (state_d != ST_IDLE) && (state_d != ST_READY);
            ready_q <= (state_d == ST_READY);
        end
    end

    seq_interval_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    key_serializer #(
        .NBITS   (KEY_BITS),
        .KEY     (KEY),
        .CLK_DIV (CLK_DIV)
    ) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (state_q == ST_SHIFT),
        .sclk_o (sclk_o),
        .sdat_o (sdat_o),
        .done_o (key_done)
    );

    assign vpp_en_o = vpp_q;
    assign busy_o   = busy_q;
    assign ready_o  = ready_q;

endmodule

// File: rtl/pgm_entry_seq_chk.sv
// Module: assertion checker for pgm_entry_seq, attached by bind below.
// Assumes: it sees only the top-level ports.
module pgm_entry_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_i,
    input logic vpp_en_o,
    input logic sclk_o,
    input logic sdat_o,
    input logic busy_o,
    input logic ready_o
);

    // R1
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !ready_o) |-> (!vpp_en_o && !sclk_o && !sdat_o));

    // R3
    key_without_voltage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !vpp_en_o);

    // R4
    data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdat_o));

    // R6
    ready_holds_voltage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (vpp_en_o && !sclk_o && !sdat_o));

    // R8
    busy_ready_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && ready_o));

    // R9
    ready_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !stop_i) |=> ready_o);

endmodule

bind pgm_entry_seq pgm_entry_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_i   (stop_i),
    .vpp_en_o (vpp_en_o),
    .sclk_o   (sclk_o),
    .sdat_o   (sdat_o),
    .busy_o   (busy_o),
    .ready_o  (ready_o)
);

// File: tb/pgm_entry_seq_tb.sv
// Bench: directed scenarios, one task each. Outputs are sampled and inputs
// driven on the falling clock edge.
`timescale 1ns/1ps
module pgm_entry_seq_tb;

    localparam int P = 4, W = 6, SA = 5, SB = 9, E = 7, D = 2;
    localparam int M = (SA > SB) ? SA : SB;
    localparam logic [31:0] K = 32'h4D434850;
    localparam int SHIFT_LEN = 64 * D;

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, stop_i = 1'b0;
    logic vpp_en_o, sclk_o, sdat_o, busy_o, ready_o;
    int n_chk = 0, n_err = 0;

    always #2 clk = !clk;

    pgm_entry_seq #(
        .PULSE_CYC(P), .PRE_KEY_CYC(W), .SETTLE_A_CYC(SA), .SETTLE_B_CYC(SB),
        .EXIT_QUIET_CYC(E), .CLK_DIV(D), .KEY_BITS(32), .KEY(K)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .vpp_en_o(vpp_en_o), .sclk_o(sclk_o), .sdat_o(sdat_o),
        .busy_o(busy_o), .ready_o(ready_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Output vector {vpp, sclk, sdat, busy, ready}
    function automatic logic [4:0] outs();
        return {vpp_en_o, sclk_o, sdat_o, busy_o, ready_o};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(outs() == 5'b0, "R1", "outputs in reset", 32'(outs()), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs() == 5'b0, "R1", "outputs idle after reset", 32'(outs()), 0);
    endtask

    // Full entry trace; inject=1 pulses start and stop mid-shift (R9).
    task automatic run_entry(input bit inject);
        int bad[6];
        logic [4:0] fa[6], fe[6];
        foreach (bad[k]) begin bad[k] = 0; fa[k] = '0; fe[k] = '0; end
        start_i = 1'b1;
        for (int i = 1; i <= P + W + SHIFT_LEN + M + 2; i++) begin
            logic [4:0] ex;
            int ph;
            @(negedge clk);
            start_i = 1'b0;
            stop_i  = 1'b0;
            if (inject && (i == 30)) begin start_i = 1'b1; stop_i = 1'b1; end
            if (i <= P) begin
                ph = 0; ex = 5'b10010;
            end else if (i <= P + W) begin
                ph = 1; ex = 5'b00010;
            end else if (i <= P + W + SHIFT_LEN) begin
                int j = i - P - W - 1;
                int b = j / (2 * D);
                logic hi = ((j % (2 * D)) >= D);
                ph = 2; ex = {1'b0, hi, K[31 - b], 1'b1, 1'b0};
            end else if (i <= P + W + SHIFT_LEN + M) begin
                ph = 3; ex = 5'b10010;
            end else begin
                ph = 4; ex = 5'b10001;
            end
            if (outs()[4:2] != ex[4:2]) begin
                if (bad[ph] == 0) begin fa[ph] = outs(); fe[ph] = ex; end
                bad[ph]++;
            end
            if (outs()[1:0] != ex[1:0]) begin
                if (bad[5] == 0) begin fa[5] = outs(); fe[5] = ex; end
                bad[5]++;
            end
        end
        chk(bad[0] == 0, "R2", "voltage pulse", 32'(fa[0]), 32'(fe[0]));
        chk(bad[1] == 0, "R3", "pre-key wait", 32'(fa[1]), 32'(fe[1]));
        chk(bad[2] == 0, inject ? "R9" : "R4", "key shift", 32'(fa[2]), 32'(fe[2]));
        chk(bad[3] == 0, "R5", "reapply settle", 32'(fa[3]), 32'(fe[3]));
        chk(bad[4] == 0, "R6", "ready lines", 32'(fa[4]), 32'(fe[4]));
        chk(bad[5] == 0, "R8", "busy/ready flags", 32'(fa[5]), 32'(fe[5]));
    endtask

    task automatic start_in_ready();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        // R9: start while ready has no effect
        chk(outs() == 5'b10001, "R9", "start in ready", 32'(outs()), 32'(5'b10001));
    endtask

    task automatic run_exit();
        int bad = 0;
        logic [4:0] fa = '0;
        stop_i = 1'b1;
        for (int i = 1; i <= E; i++) begin
            @(negedge clk);
            stop_i = 1'b0;
            if (outs() != 5'b10010) begin
                if (bad == 0) fa = outs();
                bad++;
            end
        end
        chk(bad == 0, "R7", "exit quiet hold", 32'(fa), 32'(5'b10010));
        @(negedge clk);
        chk(outs() == 5'b0, "R7", "voltage released, idle", 32'(outs()), 0);
        repeat (4) @(negedge clk);
        chk(outs() == 5'b0, "R1", "idle stays quiet", 32'(outs()), 0);
    endtask

    task automatic stop_in_idle();
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        @(negedge clk);
        // R9: stop while idle has no effect
        chk(outs() == 5'b0, "R9", "stop in idle", 32'(outs()), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        stop_in_idle();
        run_entry(1'b0);
        start_in_ready();
        run_exit();
        run_entry(1'b1);
        run_exit();
        finish_run();
    end

endmodule